// File: doc/BRIEF.md
# Four-Entry Instruction Translation Cache with Pairwise LRU

This block holds four fully associative address translations for instruction fetch. Each cycle it compares a lookup address against every stored entry and reports the result. One matching entry gives a hit, with the slot number, the physical address and the attribute bits. Two or more matching entries report a multiple hit. No matching entry reports a miss. A match needs a valid entry, an address inside the entry's page, and either a matching address-space identifier, identifier checking switched off, or an entry marked as shared.

Recency is tracked in six bits at the top of a 32-bit control register. Each bit records the order of one pair of entries. A hit or a refill on an entry applies fixed clear and set masks for that entry. The replacement slot comes from testing fixed bit patterns in priority order. When the outer unified translation cache resolves a miss, it presents the whole entry on the refill port. The block copies that entry into the replacement slot and counts the refill as a use of that slot. A global invalidate drops every entry in one cycle. The lower bits of the control register belong to other logic: they are loaded only by a register write, and a recency update never changes them.

Top module: `itlb4_lru`

## Requirements
- R1: A lookup skips an entry when the entry is not valid, or when `use_asid` is 1, the entry is not shared and its identifier differs from `cur_asid`. It also skips the entry when the address lies outside the entry's page. The page is the entry's address with its offset bits cleared, and its size code selects the offset: 0 = 1 KiB, 1 = 4 KiB, 2 = 64 KiB, 3 = 1 MiB.
- R2: With `look_valid` high, exactly one match sets `look_hit` and gives `look_idx`, `look_attr` and `look_paddr`. `look_paddr` is the entry's physical page with its offset bits cleared, OR'd with the lookup address's offset bits. Zero matches set only `look_miss`. Two or more matches set only `look_multi`. With `look_valid` low, all three flags are 0.
- R3: A hit on slot e changes the recency bits at the next clock edge (register bits 31..26). Slot 0 clears bits 31, 30 and 29. Slot 1 clears bits 28 and 27 and sets bit 31. Slot 2 clears bit 26 and sets bits 30 and 28. Slot 3 sets bits 29, 27 and 26.
- R4: Bits 25..0 of `ctl_q` are never changed by a hit or a refill. A `ctl_we` write loads all 32 bits, and it wins over a recency update in the same cycle.
- R5: `victim_idx` takes the first of these tests that holds. Slot 0 when bits 31, 30 and 29 are all 1. Slot 1 when bit 31 is 0 and bits 28 and 27 are 1. Slot 2 when bits 30 and 28 are 0 and bit 26 is 1. Slot 3 when bits 29, 27 and 26 are all 0.
- R6: When none of the R5 tests holds, `lru_err` is 1 and `victim_idx` is 0. Otherwise `lru_err` is 0.
- R7: A `fill_valid` cycle writes the whole entry into slot `victim_idx`: page, physical page, size, identifier, shared flag, valid bit and attributes. It also applies that slot's R3 recency update.
- R8: `inval_all` clears all four valid bits at the next edge. A refill in the same cycle is discarded and leaves the recency bits unchanged.
- R9: After reset, every entry is invalid and `ctl_q` is 0, so `victim_idx` is 3 and `lru_err` is 0.
- R10: A multiple hit or a miss leaves `ctl_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| look_valid | input | 1 | A lookup is presented this cycle |
| look_addr | input | VA_W | Virtual fetch address |
| use_asid | input | 1 | Compare address-space identifiers |
| cur_asid | input | ASID_W | Current address-space identifier |
| look_hit | output | 1 | Exactly one entry matched |
| look_idx | output | 2 | Slot of the matching entry |
| look_multi | output | 1 | More than one entry matched |
| look_miss | output | 1 | No entry matched |
| look_paddr | output | PA_W | Translated address on a hit, else 0 |
| look_attr | output | ATTR_W | Attribute bits of the hit entry, else 0 |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-10 | Virtual page number of the refill entry |
| fill_ppn | input | PA_W-10 | Physical page number of the refill entry |
| fill_size | input | 2 | Page size code of the refill entry |
| fill_asid | input | ASID_W | Identifier of the refill entry |
| fill_shared | input | 1 | Refill entry ignores identifiers |
| fill_entry_v | input | 1 | Valid bit of the refill entry |
| fill_attr | input | ATTR_W | Attribute bits of the refill entry |
| victim_idx | output | 2 | Slot the next refill goes to |
| lru_err | output | 1 | Recency bits match no replacement pattern |
| inval_all | input | 1 | Invalidate every entry |
| ctl_we | input | 1 | Write the control register |
| ctl_wdata | input | CTL_W | Control register write data |
| ctl_q | output | CTL_W | Control register contents |

## Verification
The properties on recency updates assume that only one writer of the control register is active in a cycle. They are therefore guarded by `ctl_we` and `fill_valid` being low. The stimulus serialises register writes, refills and lookups, except in the two cases that test precedence, and the guarded assertions exclude those cycles. The properties also assume that every input is driven to a known value from reset onward. The bench drives all inputs to 0 before it releases reset.

// File: rtl/itlb4_lru.sv
module itlb4_lru #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 29,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 4,
  parameter int CTL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_valid,
  input  logic [VA_W-1:0]   look_addr,
  input  logic              use_asid,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              look_hit,
  output logic [1:0]        look_idx,
  output logic              look_multi,
  output logic              look_miss,
  output logic [PA_W-1:0]   look_paddr,
  output logic [ATTR_W-1:0] look_attr,
  input  logic              fill_valid,
  input  logic [VA_W-11:0]  fill_vpn,
  input  logic [PA_W-11:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_shared,
  input  logic              fill_entry_v,
  input  logic [ATTR_W-1:0] fill_attr,
  output logic [1:0]        victim_idx,
  output logic              lru_err,
  input  logic              inval_all,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_q
);
  localparam int PG_LSB  = 10;
  localparam int VPN_W   = VA_W - PG_LSB;
  localparam int PPN_W   = PA_W - PG_LSB;
  localparam int LRU_LSB = CTL_W - 6;
  localparam int N_ENT   = 4;

  logic [VPN_W-1:0]  e_vpn  [N_ENT];
  logic [PPN_W-1:0]  e_ppn  [N_ENT];
  logic [1:0]        e_sz   [N_ENT];
  logic [ASID_W-1:0] e_asid [N_ENT];
  logic [ATTR_W-1:0] e_attr [N_ENT];
  logic [N_ENT-1:0]  e_sh;
  logic [N_ENT-1:0]  e_v;

  function automatic logic [VA_W-1:0] va_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return VA_W'(32'h0000_03FF);
      2'd1:    return VA_W'(32'h0000_0FFF);
      2'd2:    return VA_W'(32'h0000_FFFF);
      default: return VA_W'(32'h000F_FFFF);
    endcase
  endfunction

  function automatic logic [5:0] lru_next(input logic [5:0] l, input logic [1:0] e);
    case (e)
      2'd0:    return l & 6'b000111;
      2'd1:    return (l & 6'b111001) | 6'b100000;
      2'd2:    return (l & 6'b111110) | 6'b010100;
      default: return l | 6'b001011;
    endcase
  endfunction

  logic [N_ENT-1:0] match;
  logic [2:0]       n_match;
  logic [1:0]       idx;

  always_comb begin
    n_match = '0;
    idx     = '0;
    for (int i = 0; i < N_ENT; i++) begin
      match[i] = look_valid && e_v[i]
              && (!use_asid || e_sh[i] || (e_asid[i] == cur_asid))
              && (((look_addr ^ {e_vpn[i], {PG_LSB{1'b0}}}) & ~va_mask(e_sz[i])) == '0);
      n_match = n_match + 3'(match[i]);
      if (match[i]) idx = 2'(i);
    end
  end

  assign look_hit   = (n_match == 3'd1);
  assign look_multi = (n_match > 3'd1);
  assign look_miss  = look_valid && (n_match == 3'd0);
  assign look_idx   = idx;

  logic [PA_W-1:0] pmask;
  assign pmask      = PA_W'(va_mask(e_sz[idx]));
  assign look_paddr = look_hit ? (({e_ppn[idx], {PG_LSB{1'b0}}} & ~pmask) | (look_addr[PA_W-1:0] & pmask)) : '0;
  assign look_attr  = look_hit ? e_attr[idx] : '0;

  logic [5:0] lru;
  logic       vt0, vt1, vt2, vt3;
  assign lru = ctl_q[CTL_W-1:LRU_LSB];
  assign vt0 = lru[5] & lru[4] & lru[3];
  assign vt1 = !lru[5] & lru[2] & lru[1];
  assign vt2 = !lru[4] & !lru[2] & lru[0];
  assign vt3 = !lru[3] & !lru[1] & !lru[0];
  assign victim_idx = vt0 ? 2'd0 : vt1 ? 2'd1 : vt2 ? 2'd2 : vt3 ? 2'd3 : 2'd0;
  assign lru_err    = !(vt0 | vt1 | vt2 | vt3);

  logic fill_go;
  assign fill_go = fill_valid && !inval_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      e_v   <= '0;
    end else begin
      if (ctl_we)        ctl_q <= ctl_wdata;
      else if (fill_go)  ctl_q[CTL_W-1:LRU_LSB] <= lru_next(lru, victim_idx);
      else if (look_hit) ctl_q[CTL_W-1:LRU_LSB] <= lru_next(lru, idx);
      if (inval_all)     e_v <= '0;
      else if (fill_go)  e_v[victim_idx] <= fill_entry_v;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      e_vpn[victim_idx]  <= fill_vpn;
      e_ppn[victim_idx]  <= fill_ppn;
      e_sz[victim_idx]   <= fill_size;
      e_asid[victim_idx] <= fill_asid;
      e_attr[victim_idx] <= fill_attr;
      e_sh[victim_idx]   <= fill_shared;
    end
  end

  assert_outcome_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({look_hit, look_multi, look_miss}));

  assert_low_bits_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ctl_q[LRU_LSB-1:0] == $past(ctl_q[LRU_LSB-1:0]));

  assert_use0_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && look_idx == 2'd0 && !ctl_we && !fill_valid) |=> ctl_q[LRU_LSB+5:LRU_LSB+3] == 3'b000);

  assert_err_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lru_err |-> (victim_idx == 2'd0));

  assert_fill3_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inval_all && !ctl_we && victim_idx == 2'd3)
      |=> (ctl_q[LRU_LSB+3] && ctl_q[LRU_LSB+1] && ctl_q[LRU_LSB]));

  assert_inval_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !look_hit && !look_multi);

  assert_nohit_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((look_multi || look_miss) && !ctl_we && !fill_valid) |=> $stable(ctl_q));
endmodule

// File: tb/test_itlb4_lru.sv
module test_itlb4_lru;
  localparam int VA_W = 32, PA_W = 29, ASID_W = 8, ATTR_W = 4, CTL_W = 32;
  localparam logic [25:0] LOW = 26'h2ABCDEF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, look_valid, use_asid, look_hit, look_multi, look_miss;
  logic [VA_W-1:0]   look_addr;
  logic [ASID_W-1:0] cur_asid, fill_asid;
  logic [1:0]        look_idx, fill_size, victim_idx;
  logic [PA_W-1:0]   look_paddr;
  logic [ATTR_W-1:0] look_attr, fill_attr;
  logic              fill_valid, fill_shared, fill_entry_v, lru_err, inval_all, ctl_we;
  logic [VA_W-11:0]  fill_vpn;
  logic [PA_W-11:0]  fill_ppn;
  logic [CTL_W-1:0]  ctl_wdata, ctl_q;

  itlb4_lru i_itlb4_lru (
    .clk(clk), .rst_n(rst_n), .look_valid(look_valid), .look_addr(look_addr),
    .use_asid(use_asid), .cur_asid(cur_asid), .look_hit(look_hit), .look_idx(look_idx),
    .look_multi(look_multi), .look_miss(look_miss), .look_paddr(look_paddr),
    .look_attr(look_attr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_asid(fill_asid),
    .fill_shared(fill_shared), .fill_entry_v(fill_entry_v), .fill_attr(fill_attr),
    .victim_idx(victim_idx), .lru_err(lru_err), .inval_all(inval_all),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] m_upd(input logic [5:0] l, input int e);
    logic [5:0] r = l;
    if (e == 0) begin r[5] = 0; r[4] = 0; r[3] = 0; end
    if (e == 1) begin r[2] = 0; r[1] = 0; r[5] = 1; end
    if (e == 2) begin r[0] = 0; r[4] = 1; r[2] = 1; end
    if (e == 3) begin r[3] = 1; r[1] = 1; r[0] = 1; end
    return r;
  endfunction

  function automatic int m_vic(input logic [5:0] l);
    if (l[5] && l[4] && l[3]) return 0;
    if (!l[5] && l[2] && l[1]) return 1;
    if (!l[4] && !l[2] && l[0]) return 2;
    if (!l[3] && !l[1] && !l[0]) return 3;
    return -1;
  endfunction

  function automatic logic [5:0] lru_for(input int k);
    case (k)
      0: return 6'b111000;
      1: return 6'b000110;
      2: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [31:0] va_of(input int k);
    return (k == 3) ? 32'h4000_0000 : 32'h0010_0000 * (k + 1);
  endfunction

  function automatic logic [31:0] pa_of(input int k);
    return (k == 3) ? 32'h0A00_0000 : 32'h0080_0000 + 32'h1000 * k;
  endfunction

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic [7:0] asid, input logic sh, input logic v, input logic [3:0] attr);
    @(negedge clk);
    fill_valid = 1; fill_vpn = va[31:10]; fill_ppn = pa[28:10]; fill_size = sz;
    fill_asid = asid; fill_shared = sh; fill_entry_v = v; fill_attr = attr;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic ua, input logic [7:0] asid);
    @(negedge clk); look_valid = 1; look_addr = a; use_asid = ua; cur_asid = asid;
    #1;
  endtask

  task automatic idle();
    @(negedge clk); look_valid = 0;
    #1;
  endtask

  task automatic load_slot(input int k, input logic [31:0] va, input logic [31:0] pa,
                           input logic [1:0] sz, input logic [7:0] asid, input logic sh,
                           input logic v, input logic [3:0] attr);
    write_ctl({lru_for(k), LOW});
    fill(va, pa, sz, asid, sh, v, attr);
    chk("R7 refill recency update", ctl_q, {m_upd(lru_for(k), k), LOW});
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; look_valid = 0; look_addr = 0; use_asid = 0; cur_asid = 0;
    fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_size = 0; fill_asid = 0;
    fill_shared = 0; fill_entry_v = 0; fill_attr = 0; inval_all = 0; ctl_we = 0; ctl_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 ctl after reset", ctl_q, 32'h0);
    chk("R9 victim after reset", {30'b0, victim_idx}, 32'd3);
    chk("R9 err after reset", {31'b0, lru_err}, 32'd0);
    look(32'h0000_0000, 0, 0);
    chk("R9 all invalid", {29'b0, look_hit, look_multi, look_miss}, 32'b001);
    idle();

    for (int k = 0; k < 4; k++)
      load_slot(k, va_of(k), pa_of(k), (k == 3) ? 2'd3 : 2'd1, 8'h10 + 8'(k), k == 3, 1, 4'(k + 1));
    for (int k = 0; k < 4; k++) begin
      look(va_of(k) + 32'h123, 1, 8'h10 + 8'(k));
      chk("R7 whole entry hit", {29'b0, look_hit, look_idx}, {29'b0, 1'b1, 2'(k)});
      chk("R2 paddr", {3'b0, look_paddr}, pa_of(k) + 32'h123);
      chk("R7 attr copied", {28'b0, look_attr}, 32'(k + 1));
      idle();
    end

    look(va_of(0), 1, 8'h10);
    @(negedge clk); look_valid = 0; #1;
    look_addr = va_of(1);
    chk("R2 no lookup flags", {29'b0, look_hit, look_multi, look_miss}, 32'b0);

    for (int s = 0; s < 64; s++) begin
      write_ctl({6'(s), LOW});
      chk("R5 R6 victim", {30'b0, victim_idx}, (m_vic(6'(s)) < 0) ? 32'd0 : 32'(m_vic(6'(s))));
      chk("R6 err flag", {31'b0, lru_err}, (m_vic(6'(s)) < 0) ? 32'd1 : 32'd0);
    end

    for (int s = 0; s < 64; s++)
      for (int e = 0; e < 4; e++) begin
        write_ctl({6'(s), LOW});
        look(va_of(e) + 32'h3F0, 1, 8'h10 + 8'(e));
        idle();
        chk("R3 R4 hit update", ctl_q, {m_upd(6'(s), e), LOW});
      end

    for (int sz = 0; sz < 4; sz++) begin
      logic [31:0] bytes;
      bytes = (sz == 0) ? 32'h400 : (sz == 1) ? 32'h1000 : (sz == 2) ? 32'h1_0000 : 32'h10_0000;
      load_slot(3, 32'h4000_0000, 32'h0A00_0000, 2'(sz), 8'h33, 1, 1, 4'hC);
      look(32'h4000_0000 + bytes - 1, 1, 8'h01);
      chk("R1 last byte of page", {30'b0, look_hit, look_miss}, 32'b10);
      chk("R2 paddr offset by size", {3'b0, look_paddr}, 32'h0A00_0000 + bytes - 1);
      look(32'h4000_0000 + bytes, 1, 8'h01);
      chk("R1 past page end", {30'b0, look_hit, look_miss}, 32'b01);
      look(32'h3FFF_FFFF, 1, 8'h01);
      chk("R1 before page", {30'b0, look_hit, look_miss}, 32'b01);
      idle();
    end
    load_slot(3, 32'h4000_0400, 32'h0A00_0000, 2'd3, 8'h33, 1, 1, 4'hC);
    look(32'h4000_0010, 1, 8'h01);
    chk("R1 unaligned page base", {29'b0, look_hit, look_idx}, 32'b111);
    idle();

    load_slot(3, va_of(0), pa_of(0), 2'd1, 8'h10, 0, 1, 4'h9);
    write_ctl({6'b010101, LOW});
    look(va_of(0), 1, 8'h10);
    chk("R2 multiple hit", {29'b0, look_hit, look_multi, look_miss}, 32'b010);
    idle();
    chk("R10 multi keeps ctl", ctl_q, {6'b010101, LOW});
    look(32'h7000_0000, 0, 8'h00);
    chk("R2 miss", {29'b0, look_hit, look_multi, look_miss}, 32'b001);
    idle();
    chk("R10 miss keeps ctl", ctl_q, {6'b010101, LOW});

    load_slot(3, 32'h4000_0000, 32'h0A00_0000, 2'd3, 8'h33, 1, 0, 4'hC);
    look(32'h4000_0000, 0, 8'h33);
    chk("R1 invalid skipped", {30'b0, look_hit, look_miss}, 32'b01);
    look(va_of(0), 1, 8'h11);
    chk("R1 asid mismatch", {30'b0, look_hit, look_miss}, 32'b01);
    look(va_of(0), 0, 8'h11);
    chk("R1 asid check off", {29'b0, look_hit, look_idx}, 32'b100);
    idle();
    load_slot(3, 32'h5000_0000, 32'h0B00_0000, 2'd1, 8'h77, 1, 1, 4'h2);
    look(32'h5000_0000, 1, 8'h01);
    chk("R1 shared entry", {29'b0, look_hit, look_idx}, 32'b111);
    idle();

    write_ctl({6'b000000, LOW});
    look(va_of(0), 1, 8'h10);
    ctl_we = 1; ctl_wdata = 32'h1234_5678;
    idle(); ctl_we = 0;
    chk("R4 write wins over hit", ctl_q, 32'h1234_5678);

    write_ctl({6'b000000, LOW});
    @(negedge clk);
    inval_all = 1; fill_valid = 1; fill_vpn = 22'h18_0000; fill_ppn = 19'h1; fill_size = 1;
    fill_asid = 0; fill_shared = 1; fill_entry_v = 1; fill_attr = 0;
    @(negedge clk); inval_all = 0; fill_valid = 0; #1;
    chk("R8 fill dropped keeps ctl", ctl_q, {6'b000000, LOW});
    for (int k = 0; k < 3; k++) begin
      look(va_of(k), 0, 8'h00);
      chk("R8 entry invalidated", {30'b0, look_hit, look_miss}, 32'b01);
    end
    look(32'h6000_0000, 0, 8'h00);
    chk("R8 concurrent fill discarded", {30'b0, look_hit, look_miss}, 32'b01);
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule